// File: doc/BRIEF.md
# Memory-to-Memory DMA Channel with Interrupt Suspend

This block is one byte-wide DMA channel that copies a block of memory from a source address to a destination address. Each byte is moved by a pair of bus cycles. The read cycle fetches the byte from the source, and the write cycle stores it at the destination. Every bus cycle passes through the states T1 and T2, then zero or more wait states Tw while the memory holds off, then T3. Before its first cycle the channel asks the CPU for the bus with a request/grant handshake. It keeps the bus for the whole block and gives it back when it finishes or stops.

Software programs the source, destination and byte count through a small register write port. It then sets two bits: a master enable shared by the DMA engine and the enable of this channel. A falling edge on the active-low non-maskable interrupt input stops the copy cleanly. The current read/write pair always finishes, then the bus goes back to the CPU and the master enable is cleared. The channel enable stays set, so setting both enables again continues the copy from the exact point where it stopped.

Reset halts any copy and clears the control and status bits. It leaves the source, destination and count registers as they were, so software can still see how far the copy got.

Top module: `dma_susp_chan`

## Requirements
- R1: Each byte is moved by a read cycle (bus_rd high) immediately followed by a write cycle (bus_wr high). The two strobes are never high together, and the write drives the byte returned by the read.
- R2: bus_tstate encodes the bus state: 0 idle, 1 requesting, 2 T1, 3 T2, 4 Tw, 5 T3. T1 is followed by T2. From T2 or Tw the next state is Tw while bus_wait is high and T3 when it is low.
- R3: bus_req rises once master and channel enable are both 1 and the count is non-zero. T1 is entered only while bus_gnt is high. bus_req stays high through the final T3 and is low in the next cycle.
- R4: At the end of every write T3 the source and destination addresses each increase by one, modulo 2^AW, and the count decreases by one.
- R5: When a write brings the count to zero, the channel clears its enable, sets done, releases the bus, and drives irq high if the interrupt enable is 1.
- R6: A falling edge on nmi_n that is detected while the channel owns the bus lets the current read/write pair finish. The channel then releases the bus and clears the master enable, leaving the channel enable at 1 and done at 0. It never stops between a read and its write.
- R7: After a suspend, writing the control register with master and channel enable both 1 resumes the copy from the stored addresses and count. Each byte of the block is written exactly once.
- R8: Reset ends any copy in progress. bus_req goes to 0, bus_tstate to idle, and master enable, channel enable, interrupt enable and done to 0.
- R9: Reset does not alter the source, destination or count registers.
- R10: Register writes to source (cfg_sel 0), destination (cfg_sel 1) or count (cfg_sel 2) are ignored while bus_tstate is not idle.
- R11: Enabling the channel with a count of zero sets done and clears the channel enable at once, without requesting the bus.
- R12: A falling edge on nmi_n while the channel does not own the bus leaves the master enable unchanged.
- R13: Control writes (cfg_sel 3) set the channel enable from bit 0, the master enable from bit 1 and the interrupt enable from bit 2. A control write with bit 0 set clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | AW | Register write data |
| nmi_n | input | 1 | Active-low non-maskable interrupt, edge sensitive, asynchronous |
| bus_req | output | 1 | Bus request to the CPU |
| bus_gnt | input | 1 | Bus grant from the CPU |
| bus_tstate | output | 3 | Current bus state code |
| bus_rd | output | 1 | Read cycle in progress |
| bus_wr | output | 1 | Write cycle in progress |
| bus_addr | output | AW | Bus address: source during reads, destination during writes |
| bus_wdata | output | DW | Byte driven during the write cycle |
| bus_rdata | input | DW | Byte returned by memory, sampled at the end of read T3 |
| bus_wait | input | 1 | Wait request, sampled in T2 and Tw |
| src_q | output | AW | Current source address |
| dst_q | output | AW | Current destination address |
| cnt_q | output | CW | Bytes remaining |
| mst_en_q | output | 1 | Master enable |
| ch_en_q | output | 1 | Channel enable |
| done_q | output | 1 | Block complete flag |
| irq | output | 1 | Completion interrupt request |

## Verification
The assertions assume a well-behaved CPU side. Once bus_gnt is given it stays high until bus_req falls. bus_wait only counts in T2 and Tw, and registers are not rewritten at the very edge where the channel completes or suspends. The bench holds to these rules: its grant follows the request one cycle later, its wait generator counts a fixed number of Tw states from each T1, and it drives nmi_n only at cycle points well clear of a pair boundary. With the synchronizer delay, that makes the suspending pair known in advance.

// File: rtl/dma_susp_pkg.sv
package dma_susp_pkg;

   typedef enum logic [2:0] {
      TS_IDLE = 3'd0,
      TS_REQ  = 3'd1,
      TS_T1   = 3'd2,
      TS_T2   = 3'd3,
      TS_TW   = 3'd4,
      TS_T3   = 3'd5
   } tstate_e;

   typedef enum logic [1:0] {
      SEL_SRC = 2'd0,
      SEL_DST = 2'd1,
      SEL_CNT = 2'd2,
      SEL_CTL = 2'd3
   } sel_e;

   localparam int CTL_CH_BIT  = 0;
   localparam int CTL_MST_BIT = 1;
   localparam int CTL_IRQ_BIT = 2;

endpackage

// File: rtl/dma_susp_nmi_edge.sv
module dma_susp_nmi_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_n,
   output logic fall
);

   logic smp;
   logic prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign smp = nmi_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else begin
               chain[0] <= nmi_n;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign smp = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= smp;
   end

   assign fall = prev & ~smp;

endmodule

// File: rtl/dma_susp_seq.sv
module dma_susp_seq
   import dma_susp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       cnt_zero,
   input  logic       cnt_last,
   input  logic       bus_gnt,
   input  logic       bus_wait,
   input  logic       nmi_fall,
   output logic [2:0] tstate,
   output logic       wr_phase,
   output logic       bus_req,
   output logic       bus_rd,
   output logic       bus_wr,
   output logic       rd_latch,
   output logic       step,
   output logic       ev_done,
   output logic       ev_susp
);

   tstate_e st, st_n;
   logic    wr_ph, wr_n;
   logic    pend, pend_eff;
   logic    in_cycle;

   assign pend_eff = pend | nmi_fall;
   assign in_cycle = (st == TS_T1) || (st == TS_T2) || (st == TS_TW) || (st == TS_T3);

   always_comb begin
      st_n = st;
      wr_n = wr_ph;
      unique case (st)
         TS_IDLE: if (run && !cnt_zero) st_n = TS_REQ;
         TS_REQ: begin
            if (!run)         st_n = TS_IDLE;
            else if (bus_gnt) st_n = TS_T1;
         end
         TS_T1: st_n = TS_T2;
         TS_T2, TS_TW: st_n = bus_wait ? TS_TW : TS_T3;
         TS_T3: begin
            if (!wr_ph) begin
               st_n = TS_T1;
               wr_n = 1'b1;
            end else if (cnt_last || pend_eff || !run) begin
               st_n = TS_IDLE;
               wr_n = 1'b0;
            end else begin
               st_n = TS_T1;
               wr_n = 1'b0;
            end
         end
         default: begin
            st_n = TS_IDLE;
            wr_n = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= TS_IDLE;
         wr_ph <= 1'b0;
         pend  <= 1'b0;
      end else begin
         st    <= st_n;
         wr_ph <= wr_n;
         if (st == TS_IDLE || step) pend <= 1'b0;
         else                       pend <= pend_eff;
      end
   end

   assign tstate   = st;
   assign wr_phase = wr_ph;
   assign bus_req  = (st != TS_IDLE);
   assign bus_rd   = in_cycle && !wr_ph;
   assign bus_wr   = in_cycle && wr_ph;
   assign rd_latch = (st == TS_T3) && !wr_ph;
   assign step     = (st == TS_T3) && wr_ph;
   assign ev_done  = step && cnt_last;
   assign ev_susp  = step && !cnt_last && pend_eff;

endmodule

// File: rtl/dma_susp_regs.sv
module dma_susp_regs
   import dma_susp_pkg::*;
#(
   parameter int AW = 20,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [1:0]    cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   input  logic          busy,
   input  logic          step,
   input  logic          ev_done,
   input  logic          ev_susp,
   output logic [AW-1:0] src,
   output logic [AW-1:0] dst,
   output logic [CW-1:0] cnt,
   output logic          mst_en,
   output logic          ch_en,
   output logic          irq_en,
   output logic          done,
   output logic          cnt_zero,
   output logic          cnt_last
);

   logic load_ok;
   logic zero_start;

   assign load_ok    = cfg_wr && !busy;
   assign cnt_zero   = (cnt == '0);
   assign cnt_last   = (cnt == CW'(1));
   assign zero_start = !busy && mst_en && ch_en && cnt_zero;

   // Address and count registers are deliberately outside the reset domain.
   always_ff @(posedge clk) begin
      if (step) begin
         src <= src + AW'(1);
         dst <= dst + AW'(1);
         cnt <= cnt - CW'(1);
      end else if (load_ok) begin
         if (cfg_sel == SEL_SRC) src <= cfg_wdata;
         if (cfg_sel == SEL_DST) dst <= cfg_wdata;
         if (cfg_sel == SEL_CNT) cnt <= cfg_wdata[CW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst_en <= 1'b0;
         ch_en  <= 1'b0;
         irq_en <= 1'b0;
         done   <= 1'b0;
      end else begin
         if (cfg_wr && cfg_sel == SEL_CTL) begin
            ch_en  <= cfg_wdata[CTL_CH_BIT];
            mst_en <= cfg_wdata[CTL_MST_BIT];
            irq_en <= cfg_wdata[CTL_IRQ_BIT];
            if (cfg_wdata[CTL_CH_BIT]) done <= 1'b0;
         end
         if (ev_done || zero_start) begin
            ch_en <= 1'b0;
            done  <= 1'b1;
         end
         if (ev_susp) mst_en <= 1'b0;
      end
   end

endmodule

// File: rtl/dma_susp_chan.sv
module dma_susp_chan
   import dma_susp_pkg::*;
#(
   parameter int AW          = 20,
   parameter int CW          = 16,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [1:0]    cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   input  logic          nmi_n,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [2:0]    bus_tstate,
   output logic          bus_rd,
   output logic          bus_wr,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_wait,
   output logic [AW-1:0] src_q,
   output logic [AW-1:0] dst_q,
   output logic [CW-1:0] cnt_q,
   output logic          mst_en_q,
   output logic          ch_en_q,
   output logic          done_q,
   output logic          irq
);

   generate
      if (AW < 3 || AW > 32) begin : g_bad_aw
         $error("dma_susp_chan: AW must lie in 3..32");
      end
      if (CW < 2 || CW > AW) begin : g_bad_cw
         $error("dma_susp_chan: CW must lie in 2..AW");
      end
      if (DW < 1 || DW > 64) begin : g_bad_dw
         $error("dma_susp_chan: DW must lie in 1..64");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("dma_susp_chan: SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic          nmi_fall;
   logic          wr_phase, rd_latch, step, ev_done, ev_susp;
   logic          cnt_zero, cnt_last, irq_en;
   logic          run;
   logic [DW-1:0] dbuf;

   assign run = mst_en_q && ch_en_q;

   dma_susp_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .nmi_n (nmi_n),
      .fall  (nmi_fall)
   );

   dma_susp_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last),
      .bus_gnt  (bus_gnt),
      .bus_wait (bus_wait),
      .nmi_fall (nmi_fall),
      .tstate   (bus_tstate),
      .wr_phase (wr_phase),
      .bus_req  (bus_req),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .rd_latch (rd_latch),
      .step     (step),
      .ev_done  (ev_done),
      .ev_susp  (ev_susp)
   );

   dma_susp_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .busy      (bus_req),
      .step      (step),
      .ev_done   (ev_done),
      .ev_susp   (ev_susp),
      .src       (src_q),
      .dst       (dst_q),
      .cnt       (cnt_q),
      .mst_en    (mst_en_q),
      .ch_en     (ch_en_q),
      .irq_en    (irq_en),
      .done      (done_q),
      .cnt_zero  (cnt_zero),
      .cnt_last  (cnt_last)
   );

   always_ff @(posedge clk) begin
      if (rd_latch) dbuf <= bus_rdata;
   end

   assign bus_addr  = wr_phase ? dst_q : src_q;
   assign bus_wdata = dbuf;
   assign irq       = done_q && irq_en;

endmodule

// File: rtl/dma_susp_chan_chk.sv
module dma_susp_chan_chk
   import dma_susp_pkg::*;
#(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic [2:0]    bus_tstate,
   input logic          bus_rd,
   input logic          bus_wr,
   input logic          bus_wait,
   input logic [CW-1:0] cnt_q,
   input logic          mst_en_q,
   input logic          ch_en_q,
   input logic          done_q
);

   p_pair_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_tstate == TS_T3 && bus_rd) |=> (bus_tstate == TS_T1 && bus_wr));

   p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   p_t1_then_t2_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_tstate == TS_T1) |=> (bus_tstate == TS_T2));

   p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_tstate == TS_T2 || bus_tstate == TS_TW) && bus_wait) |=> (bus_tstate == TS_TW));

   p_wait_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_tstate == TS_T2 || bus_tstate == TS_TW) && !bus_wait) |=> (bus_tstate == TS_T3));

   p_gnt_at_t1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_tstate == TS_T1) |-> bus_gnt);

   p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_tstate == TS_T3 && bus_wr) && bus_tstate != TS_T1) |-> !bus_req);

   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_tstate == TS_T3 && bus_wr) |=> (cnt_q == $past(cnt_q) - CW'(1)));

   p_done_clears_ch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> !ch_en_q);

   p_stop_clears_mst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_tstate == TS_T3 && bus_wr) && bus_tstate == TS_IDLE && ch_en_q) |-> !mst_en_q);

endmodule

bind dma_susp_chan dma_susp_chan_chk #(.CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_req    (bus_req),
   .bus_gnt    (bus_gnt),
   .bus_tstate (bus_tstate),
   .bus_rd     (bus_rd),
   .bus_wr     (bus_wr),
   .bus_wait   (bus_wait),
   .cnt_q      (cnt_q),
   .mst_en_q   (mst_en_q),
   .ch_en_q    (ch_en_q),
   .done_q     (done_q)
);

// File: tb/dma_susp_chan_bench.sv
module dma_susp_chan_bench;

   localparam int AW = 20;
   localparam int CW = 16;
   localparam int DW = 8;

   // vector: {3'b0, irq_en, waits[3:0], count[15:0], dst[19:0], src[19:0]}
   localparam logic [63:0] VEC [0:3] = '{
      {3'b0, 1'b1, 4'd0, 16'd5, 20'h00080, 20'h00010},
      {3'b0, 1'b0, 4'd1, 16'd4, 20'h00100, 20'hFFFFE},
      {3'b0, 1'b1, 4'd3, 16'd7, 20'h345C0, 20'h12340},
      {3'b0, 1'b0, 4'd2, 16'd1, 20'h00040, 20'h0ABC0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          nmi_n = 1'b1;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic [2:0]    bus_tstate;
   logic          bus_rd, bus_wr;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata;
   logic          bus_wait = 1'b0;
   logic [AW-1:0] src_q, dst_q;
   logic [CW-1:0] cnt_q;
   logic          mst_en_q, ch_en_q, done_q, irq;

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;
   int waits_cfg = 0;
   int wctr = 0;
   logic [7:0] wmem [0:255];

   always #2 clk = ~clk;

   dma_susp_chan u_dma_susp_chan (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .nmi_n(nmi_n), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_tstate(bus_tstate),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_wait(bus_wait), .src_q(src_q), .dst_q(dst_q),
      .cnt_q(cnt_q), .mst_en_q(mst_en_q), .ch_en_q(ch_en_q), .done_q(done_q), .irq(irq)
   );

   function automatic logic [7:0] pat(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   assign bus_rdata = pat(bus_addr);

   always @(posedge clk) begin
      if (bus_wr && bus_tstate == 3'd5) begin
         wmem[bus_addr[7:0]] <= bus_wdata;
         wr_cnt <= wr_cnt + 1;
      end
   end

   always @(negedge clk) begin
      bus_gnt = bus_req && rst_n;
      if (bus_tstate == 3'd2) wctr = 0;
      if ((bus_tstate == 3'd3 || bus_tstate == 3'd4) && wctr < waits_cfg) begin
         bus_wait = 1'b1;
         wctr = wctr + 1;
      end else begin
         bus_wait = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic run_until_idle();
      int n = 0;
      while (!bus_req && n < 50) begin @(negedge clk); n++; end
      n = 0;
      while (bus_req && n < 5000) begin @(negedge clk); n++; end
   endtask

   task automatic check_data(input string tag, input logic [AW-1:0] s, input logic [AW-1:0] d, input int n);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         if (wmem[8'(d[7:0] + 8'(i))] !== pat(20'(s + 20'(i)))) bad++;
      end
      chk(bad == 0, tag, bad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [AW-1:0] s, d;
      logic [CW-1:0] n;
      logic          ie;
      int            base;
      bit            saw_req;

      // R8 reset state
      repeat (3) @(negedge clk);
      chk(bus_req == 1'b0, "R8 reset bus_req", bus_req, 0);
      chk(bus_tstate == 3'd0, "R8 reset tstate", bus_tstate, 0);
      chk({mst_en_q, ch_en_q, done_q, irq} == 4'b0, "R8 reset ctl", {mst_en_q, ch_en_q, done_q, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R1 R2 R3 R4 R5 R13
      for (int k = 0; k < 4; k++) begin
         s = VEC[k][19:0]; d = VEC[k][39:20]; n = VEC[k][55:40];
         waits_cfg = int'(VEC[k][59:56]); ie = VEC[k][60];
         base = wr_cnt;
         cfg(2'd0, s); cfg(2'd1, d); cfg(2'd2, AW'(n));
         cfg(2'd3, AW'({ie, 2'b11}));
         run_until_idle();
         chk(src_q == 20'(s + 20'(n)), "R4 src final", src_q, 20'(s + 20'(n)));
         chk(dst_q == 20'(d + 20'(n)), "R4 dst final", dst_q, 20'(d + 20'(n)));
         chk(cnt_q == '0, "R4 cnt final", cnt_q, 0);
         chk(done_q == 1'b1 && ch_en_q == 1'b0, "R5 done/ch_en", {done_q, ch_en_q}, 2'b10);
         chk(irq == ie, "R13 irq enable", irq, ie);
         chk(bus_req == 1'b0, "R3 release", bus_req, 0);
         chk(wr_cnt - base == int'(n), "R1 write count", wr_cnt - base, n);
         check_data("R1 data", s, d, int'(n));
      end
      waits_cfg = 0;

      // R6 suspend and R7 resume
      s = 20'h20000; d = 20'h00020; waits_cfg = 1;
      cfg(2'd0, s); cfg(2'd1, d); cfg(2'd2, 20'd8);
      base = wr_cnt;
      cfg(2'd3, 20'b011);
      begin
         int t = 0;
         while (wr_cnt < base + 2 && t < 2000) begin @(negedge clk); t++; end
      end
      nmi_n = 1'b0;
      begin
         int t = 0;
         while (bus_req && t < 2000) begin @(negedge clk); t++; end
      end
      chk(src_q == 20'h20003, "R6 src at suspend", src_q, 20'h20003);
      chk(dst_q == 20'h00023, "R6 dst at suspend", dst_q, 20'h00023);
      chk(cnt_q == 16'd5, "R6 cnt at suspend", cnt_q, 5);
      chk(mst_en_q == 1'b0, "R6 master cleared", mst_en_q, 0);
      chk(ch_en_q == 1'b1 && done_q == 1'b0, "R6 ch_en kept", {ch_en_q, done_q}, 2'b10);
      chk(wr_cnt - base == 3, "R6 whole pairs", wr_cnt - base, 3);
      nmi_n = 1'b1;
      repeat (5) @(negedge clk);
      cfg(2'd3, 20'b011);
      run_until_idle();
      chk(src_q == 20'h20008 && cnt_q == '0, "R7 resume end", {src_q, 12'(cnt_q)}, {20'h20008, 12'h0});
      chk(done_q == 1'b1, "R7 done", done_q, 1);
      chk(wr_cnt - base == 8, "R7 no byte repeated", wr_cnt - base, 8);
      check_data("R7 data", s, d, 8);
      waits_cfg = 0;

      // R10 writes ignored while busy
      cfg(2'd0, 20'h30000); cfg(2'd1, 20'h000A0); cfg(2'd2, 20'd4);
      base = wr_cnt;
      cfg(2'd3, 20'b011);
      begin
         int t = 0;
         while (!bus_req && t < 50) begin @(negedge clk); t++; end
      end
      cfg(2'd0, 20'h12345);
      cfg(2'd2, 20'h00FFF);
      run_until_idle();
      chk(src_q == 20'h30004, "R10 src write ignored", src_q, 20'h30004);
      chk(cnt_q == '0, "R10 cnt write ignored", cnt_q, 0);
      chk(wr_cnt - base == 4, "R10 byte total", wr_cnt - base, 4);

      // R11 zero count start
      cfg(2'd2, 20'd0);
      saw_req = 1'b0;
      cfg(2'd3, 20'b011);
      repeat (4) begin
         @(negedge clk);
         if (bus_req) saw_req = 1'b1;
      end
      chk(done_q == 1'b1 && ch_en_q == 1'b0, "R11 zero count done", {done_q, ch_en_q}, 2'b10);
      chk(saw_req == 1'b0, "R11 no request", saw_req, 0);

      // R12 edge while idle
      cfg(2'd3, 20'b010);
      nmi_n = 1'b0;
      repeat (6) @(negedge clk);
      nmi_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(mst_en_q == 1'b1, "R12 master kept", mst_en_q, 1);
      chk(bus_req == 1'b0, "R12 no request", bus_req, 0);

      // R8 R9 reset mid-transfer
      cfg(2'd0, 20'h40000); cfg(2'd1, 20'h000D0); cfg(2'd2, 20'd10);
      base = wr_cnt;
      cfg(2'd3, 20'b011);
      begin
         int t = 0;
         while (wr_cnt < base + 3 && t < 2000) begin @(negedge clk); t++; end
      end
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_req == 1'b0 && bus_tstate == 3'd0, "R8 stopped", {bus_req, bus_tstate}, 0);
      chk({mst_en_q, ch_en_q, done_q} == 3'b0, "R8 ctl cleared", {mst_en_q, ch_en_q, done_q}, 0);
      chk(src_q == 20'h40003, "R9 src kept", src_q, 20'h40003);
      chk(dst_q == 20'h000D3, "R9 dst kept", dst_q, 20'h000D3);
      chk(cnt_q == 16'd7, "R9 cnt kept", cnt_q, 7);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule